// File: doc/BRIEF.md
# Host-to-68000 Bus Transaction Bridge

This block lets a host with a narrow parallel port run single cycles on a 68000-style asynchronous bus. The host uses a 2-bit register select, a 16-bit data port, and separate read and write strobes to load a transaction into a small register file. The bridge then runs one bus cycle with the address strobe and the correct data strobes asserted. It waits for the target's acknowledge and raises a busy pin for the whole time the cycle is outstanding.

For a write, the host first sets the mode bits in the status register to word or byte, and to write. It then loads the low address half, the high address half, and finally the data word; loading the data word starts the bus cycle. For a read, the host sets the mode to read and loads the two address halves; loading the high half starts the cycle. After busy clears, the host reads the data register. In byte mode, address bit 0 chooses the byte lane. The bridge also samples the three active-low interrupt priority inputs. It shows the level in the status register and drives an active-low interrupt flag. If no acknowledge arrives within a bounded number of clocks, the cycle is abandoned and an error bit is set.

Top module: `hbus_bridge`

## Requirements
- R1: After reset the bridge is idle: `h_busy`=0, `bus_as_n`=1, `bus_uds_n`=`bus_lds_n`=1, and the status register reads 0 while all `ipl_n` inputs are high.
- R2: Register select 2 holds address bits 15:0 and select 3 holds address bits 23:16 in its bits 7:0. Host bits 15:8 written to select 3 are dropped, and that register reads them back as 0. `bus_addr` is the 24-bit concatenation of the two.
- R3: With the status mode set to write (status bit 1 = 0), a host write to the data register (select 1) starts a bus cycle. From the next clock, `bus_as_n`=0, `bus_rw`=0, `h_busy`=1 and `bus_addr` is the loaded address.
- R4: With status bit 1 = 1 (read), a host write to select 3 starts a cycle with `bus_rw`=1. After completion, reading select 1 returns the data captured from `bus_din`.
- R5: A cycle ends on the clock edge where `bus_dtack_n` is sampled low. From the next clock, `h_busy`=0 and `bus_as_n`=1.
- R6: Byte write to an even address (status bit 0 = 1, address bit 0 = 0): `bus_dout` carries the byte in both halves, only `bus_uds_n` is low.
- R7: Byte write to an odd address: `bus_dout` = {8'h00, byte}, only `bus_lds_n` is low.
- R8: Byte read returns {8'h00, `bus_din`[15:8]} at an even address and {8'h00, `bus_din`[7:0]} at an odd address.
- R9: Word accesses assert both data strobes and pass all 16 data bits unchanged.
- R10: Status layout: bit 0 byte mode, bit 1 read mode, bit 2 timeout error, bit 3 busy, bits 15:13 the interrupt level (inverted `ipl_n`, registered once). `h_irq_n` is low exactly when that level is nonzero.
- R11: If no acknowledge arrives for `TMO_CYC` clocks, the cycle ends and status bit 2 is set. The next started cycle clears it.
- R12: Host register writes while `h_busy`=1 are ignored.
- R13: `h_dout_oe` is high only while `h_rd` is high; `h_dout` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 2 | Host register select |
| h_wr | input | 1 | Host write strobe, one clock per write |
| h_rd | input | 1 | Host read strobe |
| h_din | input | 16 | Host write data |
| h_dout | output | 16 | Host read data |
| h_dout_oe | output | 1 | Host port drive enable (direction) |
| h_busy | output | 1 | High while a bus cycle is pending |
| h_irq_n | output | 1 | Active-low interrupt flag |
| ipl_n | input | 3 | Active-low interrupt priority inputs |
| bus_addr | output | 24 | Bus address |
| bus_dout | output | 16 | Bus write data |
| bus_din | input | 16 | Bus read data |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dtack_n | input | 1 | Target acknowledge, active low |

## Verification
The bench builds the bridge with `TMO_CYC` = 8 so the timeout fires after a short, exactly countable stall. This lets the bench check the last busy cycle and the first idle cycle directly. Address and data widths stay at 24 and 16, so upper host address bits above bit 23 are written and must vanish from `bus_addr`.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_DATA = 2'd1,
        SEL_ALO  = 2'd2,
        SEL_AHI  = 2'd3
    } hsel_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_BUS  = 1'b1
    } sq_e;
endpackage

// File: rtl/hbb_regs.sv
module hbb_regs
    import hbb_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    h_sel,
    input  logic          h_wr,
    input  logic [DW-1:0] h_din,
    input  logic          busy,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          byte_mode,
    output logic          rd_dir,
    output logic          start
);
    localparam int HI_W = AW - DW;

    typedef struct packed {
        logic [DW-1:0]   alo;
        logic [HI_W-1:0] ahi;
        logic [DW-1:0]   wd;
        logic            bm;
        logic            rd;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ok;

    always_comb begin
        r_d   = r_q;
        wr_ok = h_wr && !busy;
        start = 1'b0;
        if (wr_ok) begin
            unique case (hsel_e'(h_sel))
                SEL_STAT: begin
                    r_d.bm = h_din[0];
                    r_d.rd = h_din[1];
                end
                SEL_DATA: begin
                    r_d.wd = h_din;
                    start  = !r_q.rd;
                end
                SEL_ALO:  r_d.alo = h_din;
                SEL_AHI: begin
                    r_d.ahi = h_din[HI_W-1:0];
                    start   = r_q.rd;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr      = {r_q.ahi, r_q.alo};
    assign wdata     = r_q.wd;
    assign byte_mode = r_q.bm;
    assign rd_dir    = r_q.rd;

    // R12
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && h_wr) |=> $stable(r_q));
endmodule

// File: rtl/hbb_lanes.sv
module hbb_lanes #(
    parameter int DW = 16
) (
    input  logic          active,
    input  logic          addr0,
    input  logic          byte_mode,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_din,
    output logic          uds_n,
    output logic          lds_n,
    output logic [DW-1:0] bus_dout,
    output logic [DW-1:0] rd_steer
);
    localparam int HB = DW / 2;

    logic use_u, use_l;

    always_comb begin
        if (!byte_mode) begin
            use_u    = 1'b1;
            use_l    = 1'b1;
            bus_dout = wdata;
            rd_steer = bus_din;
        end else if (!addr0) begin
            use_u    = 1'b1;
            use_l    = 1'b0;
            bus_dout = {wdata[HB-1:0], wdata[HB-1:0]};
            rd_steer = {{HB{1'b0}}, bus_din[DW-1:HB]};
        end else begin
            use_u    = 1'b0;
            use_l    = 1'b1;
            bus_dout = {{HB{1'b0}}, wdata[HB-1:0]};
            rd_steer = {{HB{1'b0}}, bus_din[HB-1:0]};
        end
        uds_n = !(active && use_u);
        lds_n = !(active && use_l);
    end
endmodule

// File: rtl/hbb_seq.sv
module hbb_seq
    import hbb_pkg::*;
#(
    parameter int DW      = 16,
    parameter int TMO_CYC = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd_dir,
    input  logic          dtack_n,
    input  logic [DW-1:0] rd_in,
    output logic          active,
    output logic [DW-1:0] rdata,
    output logic          tmo_err
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    typedef struct packed {
        sq_e           st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rdat;
        logic          err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start) begin
                    s_d.st  = SQ_BUS;
                    s_d.cnt = '0;
                    s_d.err = 1'b0;
                end
            end
            SQ_BUS: begin
                if (!dtack_n) begin
                    s_d.st = SQ_IDLE;
                    if (rd_dir) s_d.rdat = rd_in;
                end else if (s_q.cnt == LAST) begin
                    s_d.st  = SQ_IDLE;
                    s_d.err = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, cnt: '0, rdat: '0, err: 1'b0};
        else        s_q <= s_d;
    end

    assign active  = (s_q.st == SQ_BUS);
    assign rdata   = s_q.rdat;
    assign tmo_err = s_q.err;

    // R3
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active) |=> active);
    // R5
    ack_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !dtack_n) |=> !active);
    // R11
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (s_q.cnt < CW'(TMO_CYC)));
endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge
    import hbb_pkg::*;
#(
    parameter int AW      = 24,
    parameter int DW      = 16,
    parameter int IPL_W   = 3,
    parameter int TMO_CYC = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    h_sel,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [DW-1:0] h_din,
    output logic [DW-1:0] h_dout,
    output logic          h_dout_oe,
    output logic          h_busy,
    output logic          h_irq_n,
    input  logic [IPL_W-1:0] ipl_n,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    input  logic [DW-1:0] bus_din,
    output logic          bus_as_n,
    output logic          bus_uds_n,
    output logic          bus_lds_n,
    output logic          bus_rw,
    input  logic          bus_dtack_n
);
    localparam int HI_W = AW - DW;

    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata, rd_steer, status;
    logic          byte_mode, rd_dir, start, active, tmo_err;
    logic [IPL_W-1:0] lvl_d, lvl_q;

    hbb_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_din(h_din),
        .busy(active), .addr(addr), .wdata(wdata), .byte_mode(byte_mode),
        .rd_dir(rd_dir), .start(start)
    );

    hbb_lanes #(.DW(DW)) u_lanes (
        .active(active), .addr0(addr[0]), .byte_mode(byte_mode),
        .wdata(wdata), .bus_din(bus_din), .uds_n(bus_uds_n),
        .lds_n(bus_lds_n), .bus_dout(bus_dout), .rd_steer(rd_steer)
    );

    hbb_seq #(.DW(DW), .TMO_CYC(TMO_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_dir(rd_dir),
        .dtack_n(bus_dtack_n), .rd_in(rd_steer), .active(active),
        .rdata(rdata), .tmo_err(tmo_err)
    );

    always_comb lvl_d = ~ipl_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    always_comb begin
        status = '0;
        status[0] = byte_mode;
        status[1] = rd_dir;
        status[2] = tmo_err;
        status[3] = active;
        status[DW-1 -: IPL_W] = lvl_q;
    end

    always_comb begin
        h_dout = '0;
        if (h_rd) begin
            unique case (hsel_e'(h_sel))
                SEL_STAT: h_dout = status;
                SEL_DATA: h_dout = rdata;
                SEL_ALO:  h_dout = addr[DW-1:0];
                SEL_AHI:  h_dout = DW'(addr[AW-1 -: HI_W]);
                default:  h_dout = '0;
            endcase
        end
    end

    assign h_dout_oe = h_rd;
    assign h_busy    = active;
    assign h_irq_n   = (lvl_q == '0);
    assign bus_addr  = addr;
    assign bus_as_n  = !active;
    assign bus_rw    = active ? rd_dir : 1'b1;

    // R6
    byte_one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && byte_mode) |-> ($countones({bus_uds_n, bus_lds_n}) == 1));
    // R10
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_irq_n == (h_dout_oe && hsel_e'(h_sel) == SEL_STAT ?
                     (h_dout[DW-1 -: IPL_W] == '0) : h_irq_n)));
endmodule

// File: tb/hbus_bridge_bench.sv
`timescale 1ns/1ps
module hbus_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  h_sel = 2'd0;
    logic        h_wr = 1'b0, h_rd = 1'b0;
    logic [15:0] h_din = '0;
    logic [15:0] h_dout;
    logic        h_dout_oe, h_busy, h_irq_n;
    logic [2:0]  ipl_n = 3'b111;
    logic [23:0] bus_addr;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_as_n, bus_uds_n, bus_lds_n, bus_rw;
    logic        bus_dtack_n = 1'b1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hbus_bridge #(.TMO_CYC(8)) u_hbus_bridge (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd),
        .h_din(h_din), .h_dout(h_dout), .h_dout_oe(h_dout_oe), .h_busy(h_busy),
        .h_irq_n(h_irq_n), .ipl_n(ipl_n), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_din(bus_din), .bus_as_n(bus_as_n),
        .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_rw(bus_rw),
        .bus_dtack_n(bus_dtack_n)
    );

    typedef struct packed {
        logic        rd;
        logic        bm;
        logic [31:0] addr;
        logic [15:0] wd;
        logic [15:0] bd;
        logic        uds_n;
        logic        lds_n;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 32'h1234_5678, 16'hBEEF, 16'h0000, 1'b0, 1'b0, 16'hBEEF},
        '{1'b0, 1'b1, 32'h00A0_0010, 16'h005A, 16'h0000, 1'b0, 1'b1, 16'h5A5A},
        '{1'b0, 1'b1, 32'h00A0_0011, 16'h00C3, 16'h0000, 1'b1, 1'b0, 16'h00C3},
        '{1'b1, 1'b0, 32'h00FF_FFFE, 16'h0000, 16'h1357, 1'b0, 1'b0, 16'h1357},
        '{1'b1, 1'b1, 32'h0000_0100, 16'h0000, 16'hABCD, 1'b0, 1'b1, 16'h00AB},
        '{1'b1, 1'b1, 32'hFF00_0101, 16'h0000, 16'hABCD, 1'b1, 1'b0, 16'h00CD}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        h_sel = sel; h_din = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] sel, output logic [15:0] d);
        h_sel = sel; h_rd = 1'b1;
        #1;
        d = h_dout;
        h_rd = 1'b0;
    endtask

    logic [15:0] rv;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", h_busy, 0);
        chk("R1 as_n", bus_as_n, 1);
        chk("R1 strobes", {bus_uds_n, bus_lds_n}, 2'b11);
        hread(2'd0, rv);
        chk("R1 status", rv, 16'h0000);
        // R13 port idle
        chk("R13 oe low", h_dout_oe, 0);
        chk("R13 dout zero", h_dout, 0);

        // main table
        for (int i = 0; i < NV; i++) begin
            hwrite(2'd0, {14'd0, VEC[i].rd, VEC[i].bm});
            hwrite(2'd2, VEC[i].addr[15:0]);
            hwrite(2'd3, VEC[i].addr[31:16]);
            if (!VEC[i].rd) hwrite(2'd1, VEC[i].wd);
            chk(VEC[i].rd ? "R4 start" : "R3 start", {h_busy, bus_as_n}, 2'b10);
            chk("R3 rw", bus_rw, VEC[i].rd);
            chk("R2 bus_addr", bus_addr, VEC[i].addr[23:0]);
            chk(VEC[i].bm ? (VEC[i].addr[0] ? "R7 strobes" : "R6 strobes") : "R9 strobes",
                {bus_uds_n, bus_lds_n}, {VEC[i].uds_n, VEC[i].lds_n});
            if (!VEC[i].rd)
                chk(VEC[i].bm ? (VEC[i].addr[0] ? "R7 dout" : "R6 dout") : "R9 dout",
                    bus_dout, VEC[i].exp);
            bus_din = VEC[i].bd; bus_dtack_n = 1'b0;
            @(negedge clk);
            bus_dtack_n = 1'b1;
            chk("R5 done", {h_busy, bus_as_n}, 2'b01);
            if (VEC[i].rd) begin
                hread(2'd1, rv);
                chk(VEC[i].bm ? "R8 byte read" : "R4 word read", rv, VEC[i].exp);
            end
        end

        // R2 readback of address halves
        hwrite(2'd0, 16'h0002);
        hwrite(2'd2, 16'hC0DE);
        hread(2'd2, rv);
        chk("R2 alo readback", rv, 16'hC0DE);
        hread(2'd3, rv);
        chk("R2 ahi readback", rv, 16'h0000);

        // R11 timeout: read cycle with no acknowledge
        hwrite(2'd3, 16'h7F33);
        chk("R11 busy start", h_busy, 1);
        // R12 write attempt while busy
        hwrite(2'd2, 16'hFFFF);
        chk("R12 addr unchanged", bus_addr, 24'h33C0DE);
        repeat (5) @(negedge clk);
        chk("R11 busy at limit", h_busy, 1);
        @(negedge clk);
        chk("R11 ended", {h_busy, bus_as_n}, 2'b01);
        hread(2'd0, rv);
        chk("R11 err set", rv[3:0], 4'b0110);
        hread(2'd2, rv);
        chk("R12 alo kept", rv, 16'hC0DE);
        // next start clears error
        hwrite(2'd3, 16'h0033);
        hread(2'd0, rv);
        chk("R11 err cleared", rv[3:0], 4'b1010);
        bus_dtack_n = 1'b0;
        @(negedge clk);
        bus_dtack_n = 1'b1;

        // R10 interrupt level
        ipl_n = 3'b010;
        @(negedge clk);
        chk("R10 irq_n", h_irq_n, 0);
        hread(2'd0, rv);
        chk("R10 level", rv[15:13], 3'd5);
        chk("R10 mode bits", rv[1:0], 2'b10);
        ipl_n = 3'b111;
        @(negedge clk);
        chk("R10 irq_n clear", h_irq_n, 1);
        // R13 drive enable follows strobe
        h_rd = 1'b1; #1;
        chk("R13 oe high", h_dout_oe, 1);
        h_rd = 1'b0; #1;
        chk("R13 oe low again", h_dout_oe, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule